// File: doc/BRIEF.md
# Lookup-Table Logic Cluster with Carry and Cascade Chains

This block is a cluster of configurable logic elements for a programmable fabric. Each element has a four-input lookup table, one flip-flop, a selectable arithmetic mode that uses a dedicated ripple carry path, and a cascade link that ANDs its own result with the result of the element below it. Together these links build wide AND functions without using more table inputs. By default a cluster has eight elements. Every element input is picked through local routing from a shared pool. The pool holds the cluster's external inputs and the flip-flop outputs of all elements in the cluster, so any element can feed any other.

Configuration is serial. While the load enable is high, one bit enters a single cluster-wide shift chain on each clock. Each element reads its own slice of that chain. The outputs carry no meaning until the whole chain has been shifted in.

Top module: `lut_cluster`

## Requirements
- R1: With arithmetic and cascade off, an element's result is bit A of its 16-bit table word (word bits [15:0] of its slice). A is formed with bit j equal to the element's input j.
- R2: With the register select bit set, an element output shows the result captured at the previous rising clock edge and does not follow input changes between edges. With the bit clear, the output is the result itself, combinationally.
- R3: An active-low asynchronous reset clears every flip-flop and every configuration bit. Cluster outputs and carry_out are then 0.
- R4: While cfg_en is high, each rising edge shifts cfg_bit in at the top of a chain of N_ELEM*35 bits, toward bit 0. After a full load, the first bit sent sits at bit 0 of element 0's slice, and element e owns chain bits [35e+34:35e].
- R5: Input j of an element is chosen by the 4-bit field at slice bits [19+4j:16+4j]. Values 0 to 7 choose external input ext_in[value]. Values 8 to 15 choose the flip-flop output of element value-8.
- R6: With slice bit 33 set, the element is a full adder: its result is in0 XOR in1 XOR carry-in, and its carry-out is the majority of the three. Element 0 takes carry_in. Element k takes the carry-out of element k-1. An element with bit 33 clear drives carry-out 0. carry_out is element N_ELEM-1's carry-out.
- R7: With slice bit 34 set, the element's result is ANDed with the cascade input, which is the final result of element k-1. Element 0's cascade input is 1. With bit 34 clear, the chain restarts at that element.
- R8: While cfg_en is low, cfg_bit has no effect and the configuration is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for flip-flops and configuration chain |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| ext_in | input | N_EXT | External inputs into the local routing pool |
| carry_in | input | 1 | Carry into element 0 |
| le_out | output | N_ELEM | Element outputs, registered or direct per element |
| carry_out | output | 1 | Carry out of the last element |

## Verification
The bench builds the default configuration: four table inputs, eight elements and eight external inputs, which gives a 16-entry routing pool and a 280-bit chain. At this size the bench can sweep all 256 external input vectors in table mode, cascade mode with and without a chain break, and registered mode. It also covers all 512 operand and carry-in combinations of the eight-bit adder that the arithmetic mode forms. A feedback shift register, built only from flip-flop-to-element routing, exercises the local pool's element half.

// File: rtl/le_pkg.sv
package le_pkg;
   // mode bits follow the table word and the routing fields in each slice
   localparam int MODE_BITS  = 3;
   localparam int MODE_REG   = 0;
   localparam int MODE_ARITH = 1;
   localparam int MODE_CASC  = 2;

   function automatic logic fa_sum(input logic a, input logic b, input logic c);
      return a ^ b ^ c;
   endfunction

   function automatic logic fa_carry(input logic a, input logic b, input logic c);
      return (a & b) | (c & (a ^ b));
   endfunction
endpackage

// File: rtl/le_cfg_shift.sv
module le_cfg_shift #(
   parameter int TOT = 280
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shift_en,
   input  logic           bit_in,
   output logic [TOT-1:0] chain
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        chain <= '0;
      else if (shift_en) chain <= {bit_in, chain[TOT-1:1]};
   end
endmodule

// File: rtl/le_route.sv
module le_route #(
   parameter int N_SRC = 16,
   parameter int SEL_W = 4
) (
   input  logic [N_SRC-1:0] pool,
   input  logic [SEL_W-1:0] sel,
   output logic             y
);
   always_comb begin
      y = 1'b0;
      for (int i = 0; i < N_SRC; i++)
         if (sel == SEL_W'(i)) y = pool[i];
   end
endmodule

// File: rtl/le_cell.sv
module le_cell
   import le_pkg::*;
#(
   parameter  int K          = 4,
   parameter  int N_SRC      = 16,
   parameter  int SEL_W      = 4,
   localparam int LUT_BITS   = 1 << K,
   localparam int MODE_BASE  = LUT_BITS + K * SEL_W,
   localparam int CFG_W      = MODE_BASE + MODE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg,
   input  logic [N_SRC-1:0] pool,
   input  logic             carry_i,
   input  logic             casc_i,
   output logic             d_o,
   output logic             q_o,
   output logic             out_o,
   output logic             carry_o
);
   logic [K-1:0]        lin;
   logic [LUT_BITS-1:0] lut_word;
   logic                f_lut, f_add, f_sel;
   logic                m_reg, m_arith, m_casc;

   for (genvar j = 0; j < K; j++) begin : g_in
      le_route #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_rt (
         .pool (pool),
         .sel  (cfg[LUT_BITS + j*SEL_W +: SEL_W]),
         .y    (lin[j])
      );
   end

   assign lut_word = cfg[LUT_BITS-1:0];
   assign m_reg    = cfg[MODE_BASE + MODE_REG];
   assign m_arith  = cfg[MODE_BASE + MODE_ARITH];
   assign m_casc   = cfg[MODE_BASE + MODE_CASC];

   assign f_lut   = lut_word[lin];
   assign f_add   = fa_sum(lin[0], lin[1], carry_i);
   assign carry_o = m_arith & fa_carry(lin[0], lin[1], carry_i);
   assign f_sel   = m_arith ? f_add : f_lut;
   assign d_o     = m_casc ? (f_sel & casc_i) : f_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= d_o;
   end

   assign out_o = m_reg ? q_o : d_o;
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
   import le_pkg::*;
#(
   parameter int K      = 4,
   parameter int N_ELEM = 8,
   parameter int N_EXT  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_bit,
   input  logic [N_EXT-1:0]  ext_in,
   input  logic              carry_in,
   output logic [N_ELEM-1:0] le_out,
   output logic              carry_out
);
   localparam int N_SRC    = N_EXT + N_ELEM;
   localparam int SEL_W    = $clog2(N_SRC);
   localparam int LUT_BITS = 1 << K;
   localparam int CFG_W    = LUT_BITS + K * SEL_W + MODE_BITS;
   localparam int TOT      = N_ELEM * CFG_W;

   if (K < 2) begin : g_bad_k
      $error("lut_cluster: arithmetic mode needs at least two table inputs");
   end
   if (N_ELEM < 1 || N_EXT < 1) begin : g_bad_n
      $error("lut_cluster: element and external input counts must be positive");
   end

   logic [TOT-1:0]    cfg_chain;
   logic [N_ELEM-1:0] le_d, le_q;
   logic [N_ELEM:0]   carry_c, casc_c;
   logic [N_SRC-1:0]  pool;

   le_cfg_shift #(.TOT(TOT)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_en),
      .bit_in   (cfg_bit),
      .chain    (cfg_chain)
   );

   assign pool       = {le_q, ext_in};
   assign carry_c[0] = carry_in;
   assign casc_c[0]  = 1'b1;

   for (genvar e = 0; e < N_ELEM; e++) begin : g_el
      le_cell #(.K(K), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg     (cfg_chain[e*CFG_W +: CFG_W]),
         .pool    (pool),
         .carry_i (carry_c[e]),
         .casc_i  (casc_c[e]),
         .d_o     (le_d[e]),
         .q_o     (le_q[e]),
         .out_o   (le_out[e]),
         .carry_o (carry_c[e+1])
      );
      assign casc_c[e+1] = le_d[e];
   end

   assign carry_out = carry_c[N_ELEM];
endmodule

// File: rtl/lut_cluster_chk.sv
module lut_cluster_chk
   import le_pkg::*;
#(
   parameter int N_ELEM    = 8,
   parameter int CFG_W     = 35,
   parameter int MODE_BASE = 32,
   parameter int TOT       = 280
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic              cfg_bit,
   input logic [TOT-1:0]    cfg_chain,
   input logic [N_ELEM-1:0] le_d,
   input logic [N_ELEM-1:0] le_q
);
   p_cfg_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> cfg_chain[TOT-1] == $past(cfg_bit));

   p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> $stable(cfg_chain));

   for (genvar e = 0; e < N_ELEM; e++) begin : g_e
      p_ff_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> le_q[e] == $past(le_d[e]));
      if (e > 0) begin : g_c
         p_casc_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_chain[e*CFG_W + MODE_BASE + MODE_CASC] && !le_d[e-1]) |-> !le_d[e]);
      end
   end
endmodule

bind lut_cluster lut_cluster_chk #(
   .N_ELEM(N_ELEM), .CFG_W(CFG_W), .MODE_BASE(LUT_BITS + K*SEL_W), .TOT(TOT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
   .cfg_chain(cfg_chain), .le_d(le_d), .le_q(le_q)
);

// File: tb/lut_cluster_tb.sv
`timescale 1ns/1ps
module lut_cluster_tb;
   localparam int N  = 8;
   localparam int CW = 35;
   localparam int TOT = N * CW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 1'b0, cfg_bit = 1'b0, carry_in = 1'b0;
   logic [7:0] ext_in = '0;
   logic [7:0] le_out;
   logic carry_out;
   logic [CW-1:0] cfgw [N];
   int n_chk = 0, n_err = 0;

   always #4 clk = ~clk;

   lut_cluster u_dut (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
      .ext_in(ext_in), .carry_in(carry_in), .le_out(le_out), .carry_out(carry_out));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] mk(input logic [15:0] lut, input int s0, input int s1,
         input int s2, input int s3, input logic rg, input logic ar, input logic cs);
      logic [CW-1:0] w;
      w = {cs, ar, rg, 4'(s3), 4'(s2), 4'(s1), 4'(s0), lut};
      return w;
   endfunction

   // R4: first bit sent ends at chain bit 0
   task automatic load_cfg();
      for (int i = 0; i < TOT; i++) begin
         @(negedge clk);
         cfg_en  = 1'b1;
         cfg_bit = cfgw[i / CW][i % CW];
      end
      @(negedge clk);
      cfg_en = 1'b0;
   endtask

   function automatic logic [15:0] lut_of(input int e);
      return 16'h6B2D ^ (16'(e) * 16'h1111);
   endfunction

   function automatic logic [7:0] f_lut(input logic [7:0] v);
      logic [7:0] r;
      for (int e = 0; e < N; e++) begin
         logic [3:0] a;
         a = {v[(e+3)%8], v[(e+2)%8], v[(e+1)%8], v[e]};
         r[e] = lut_of(e)[a];
      end
      return r;
   endfunction

   function automatic logic [7:0] f_casc(input logic [7:0] v, input logic [7:0] m);
      logic [7:0] r;
      logic c;
      c = 1'b1;
      for (int e = 0; e < N; e++) begin
         r[e] = m[e] ? (v[e] & c) : v[e];
         c = r[e];
      end
      return r;
   endfunction

   task automatic cfg_casc(input logic [7:0] m);
      for (int e = 0; e < N; e++) cfgw[e] = mk(16'hAAAA, e, 0, 0, 0, 1'b0, 1'b0, m[e]);
      load_cfg();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] sr;
      logic [8:0] s;
      ext_in = 8'h5A; carry_in = 1'b1;
      #20;
      chk("R3 out in reset", 32'(le_out), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R3 out after reset", 32'(le_out), 0);
      chk("R3 carry after reset", 32'(carry_out), 0);

      // R1 / R5: tables with external routing, combinational
      for (int e = 0; e < N; e++)
         cfgw[e] = mk(lut_of(e), e, (e+1)%8, (e+2)%8, (e+3)%8, 1'b0, 1'b0, 1'b0);
      load_cfg();
      for (int v = 0; v < 256; v++) begin
         @(negedge clk); ext_in = 8'(v); #1;
         chk("R1 table lookup", 32'(le_out), 32'(f_lut(8'(v))));
      end

      // R2: registered output
      for (int e = 0; e < N; e++)
         cfgw[e] = mk(lut_of(e), e, (e+1)%8, (e+2)%8, (e+3)%8, 1'b1, 1'b0, 1'b0);
      load_cfg();
      for (int v = 0; v < 256; v++) begin
         @(negedge clk); ext_in = 8'(v); #1;
         if (v > 0) chk("R2 holds between edges", 32'(le_out), 32'(f_lut(8'(v-1))));
         @(posedge clk); #1;
         chk("R2 registered output", 32'(le_out), 32'(f_lut(8'(v))));
      end

      // R3: reset clears configuration
      @(negedge clk); rst_n = 1'b0; #1;
      chk("R3 reset clears config", 32'(le_out), 0);
      @(negedge clk); rst_n = 1'b1;

      // R5: flip-flop feedback ring forms a shift register
      cfgw[0] = mk(16'hAAAA, 0, 0, 0, 0, 1'b1, 1'b0, 1'b0);
      for (int e = 1; e < N; e++) cfgw[e] = mk(16'hAAAA, 8 + e - 1, 0, 0, 0, 1'b1, 1'b0, 1'b0);
      load_cfg();
      for (int i = 0; i < 8; i++) begin @(negedge clk); ext_in = 8'h00; end
      @(negedge clk);
      sr = '0;
      for (int i = 0; i < 40; i++) begin
         ext_in[0] = ((i * 5 + i / 3) % 3) == 1;
         sr = {sr[6:0], ext_in[0]};
         @(posedge clk); #1;
         chk("R5 feedback routing", 32'(le_out), 32'(sr));
         @(negedge clk);
      end

      // R6: eight-bit adder across the carry chain
      for (int e = 0; e < N; e++) cfgw[e] = mk(16'h0000, e, (e+4)%8, 0, 0, 1'b0, 1'b1, 1'b0);
      load_cfg();
      for (int c = 0; c < 2; c++)
         for (int v = 0; v < 256; v++) begin
            @(negedge clk); ext_in = 8'(v); carry_in = 1'(c); #1;
            s = 9'(v) + 9'({ext_in[3:0], ext_in[7:4]}) + 9'(c);
            chk("R6 sum and carry", 32'({carry_out, le_out}), 32'(s));
         end

      // R7: full cascade, then a chain broken at element 4
      cfg_casc(8'hFF);
      for (int v = 0; v < 256; v++) begin
         @(negedge clk); ext_in = 8'(v); carry_in = 1'b1; #1;
         chk("R7 full cascade", 32'(le_out), 32'(f_casc(8'(v), 8'hFF)));
      end
      chk("R6 non-arith carry is 0", 32'(carry_out), 0);
      cfg_casc(8'hEF);
      for (int v = 0; v < 256; v++) begin
         @(negedge clk); ext_in = 8'(v); #1;
         chk("R7 broken cascade", 32'(le_out), 32'(f_casc(8'(v), 8'hEF)));
      end

      // R8: serial data ignored while enable is low
      for (int i = 0; i < 60; i++) begin
         @(negedge clk); cfg_en = 1'b0; cfg_bit = ((i * 7) % 3) != 0;
      end
      for (int v = 0; v < 256; v += 17) begin
         @(negedge clk); ext_in = 8'(v); #1;
         chk("R8 config unchanged", 32'(le_out), 32'(f_casc(8'(v), 8'hEF)));
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule